// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Periodic Tap

This block divides a 32.768 kHz oscillator enable through a 15-stage binary chain. The full chain yields a once-per-second update strobe, which the time and calendar counters use to advance. Ahead of each strobe, the block raises a status bit, so that software knows an update is near. The bit is high for the 16 oscillator cycles (about 488 µs) before the strobe. While it is low, software can read time data safely.

A 4-bit rate field picks one tap of the same chain as a periodic event source. Each tap event sets a sticky flag, which a read-clear pulse drops. The flag raises the interrupt request only while the enable bit is set.

A 3-bit chain-control field selects the chain mode:
- normal counting;
- one of three test lengths that skip 5, 10 or 15 stages;
- a reset hold;
- a freeze (the invalid codes).

Top module: `rtc_divchain`

## Requirements
- R1: After reset, update_stb, upd_busy, per_flag and irq are all low.
- R2: With chain_mode 3'b010, update_stb pulses on every 32768th osc_tick. The first pulse comes on the 32768th tick after the mode leaves a reset code.
- R3: Chain codes shorten the period of update_stb as follows: 3'b011 gives 1024 ticks, 3'b100 gives 32 ticks and 3'b101 gives every tick.
- R4: Chain codes 3'b110 and 3'b111 hold the count at zero. While they are active, neither update_stb nor upd_busy is ever high.
- R5: Chain codes 3'b000 and 3'b001 freeze the count without clearing it. Returning to a running code resumes from the frozen value.
- R6: With period P ticks and P above 16, upd_busy goes high after tick number P−16 of each period. It stays high through the strobe tick and is low in the clock cycle after update_stb. With P = 1, upd_busy stays low.
- R7: For rate codes 3 to 15, per_flag sets every 2^(code−1) ticks. After a restart, the first event falls on exactly that tick.
- R8: Rate code 1 behaves as code 8 (128 ticks). Rate code 2 behaves as code 9 (256 ticks).
- R9: Rate code 0 never sets per_flag.
- R10: per_flag stays set until a flag_clr pulse. When a tap event and flag_clr come in the same cycle, the flag stays set.
- R11: irq is high exactly when per_flag is set and per_ie is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| chain_mode | input | 3 | Chain control code |
| rate_sel | input | 4 | Periodic tap select |
| per_ie | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Read-clear pulse for per_flag |
| update_stb | output | 1 | Once-per-chain-period update strobe |
| upd_busy | output | 1 | Update-in-progress status |
| per_flag | output | 1 | Sticky periodic event flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that every input is synchronous to clk and that osc_tick is an enable of one clock per oscillator cycle. The busy window stays aligned only when the chain length changes while the count is zero. The stimulus therefore changes chain_mode only with osc_tick low. Each new length and each rate sweep starts from a reset code, so every expected strobe, busy window and tap event follows arithmetically from a tick index that the bench keeps itself.

// File: rtl/rtc_divchain.sv
module rtc_divchain #(
  parameter int STAGES = 15,
  parameter int STEP   = 5,
  parameter int LEAD   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [2:0] chain_mode,
  input  logic [3:0] rate_sel,
  input  logic       per_ie,
  input  logic       flag_clr,
  output logic       update_stb,
  output logic       upd_busy,
  output logic       per_flag,
  output logic       irq
);
  localparam int LW = $clog2(STAGES + 1);
  localparam logic [LW-1:0] FULL = LW'(STAGES);
  localparam logic [STAGES-1:0] ONES = {STAGES{1'b1}};
  localparam logic [STAGES-1:0] LEADV = STAGES'(LEAD);

  logic [STAGES-1:0] cnt, mask, tmask;
  logic [LW-1:0] len;
  logic [3:0] eff;
  logic running, hold_rst, adv, busy_set, tap_evt;

  always_comb begin
    case (chain_mode)
      3'b011:  len = LW'(STAGES - STEP);
      3'b100:  len = LW'(STAGES - 2 * STEP);
      3'b101:  len = LW'(STAGES - 3 * STEP);
      default: len = FULL;
    endcase
    case (rate_sel)
      4'd1:    eff = 4'd8;
      4'd2:    eff = 4'd9;
      default: eff = rate_sel;
    endcase
  end

  assign hold_rst = chain_mode[2] & chain_mode[1];
  assign running  = (chain_mode >= 3'b010) & ~hold_rst;
  assign adv      = osc_tick & running;
  assign mask     = ONES >> (FULL - len);
  assign tmask    = ONES >> (FULL - LW'(eff) + LW'(1));

  assign update_stb = adv & (&(cnt | ~mask));
  assign busy_set   = adv & (mask >= LEADV) & ((cnt & mask) == (mask - LEADV));
  assign tap_evt    = adv & (rate_sel != 4'd0) & (&(cnt | ~tmask));
  assign irq        = per_flag & per_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      upd_busy <= 1'b0;
      per_flag <= 1'b0;
    end else begin
      if (hold_rst)     cnt <= '0;
      else if (adv)     cnt <= cnt + 1'b1;

      if (hold_rst || update_stb) upd_busy <= 1'b0;
      else if (busy_set)          upd_busy <= 1'b1;

      if (tap_evt)       per_flag <= 1'b1;
      else if (flag_clr) per_flag <= 1'b0;
    end
  end

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> (cnt == '0) && !upd_busy);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !hold_rst) |=> $stable(cnt) && $stable(upd_busy));
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !upd_busy);
  p_rate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0 && !per_flag) |=> !per_flag);
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_evt |=> per_flag);
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tap_evt) |=> !per_flag);
endmodule

// File: tb/rtc_divchain_test.sv
module rtc_divchain_test;
  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, per_ie = 1'b0, flag_clr = 1'b0;
  logic [2:0] chain_mode = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic update_stb, upd_busy, per_flag, irq;
  int checks = 0, errors = 0, idx = 0;

  always #2.5 clk = ~clk;

  rtc_divchain uut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .chain_mode(chain_mode),
    .rate_sel(rate_sel), .per_ie(per_ie), .flag_clr(flag_clr), .update_stb(update_stb),
    .upd_busy(upd_busy), .per_flag(per_flag), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, idx);
    end
  endtask

  function automatic bit busy_exp(input int p, input int i);
    return (p > 16) && ((i % p) >= p - 16);
  endfunction

  task automatic tick(input int p, input bit counting, input string req);
    @(negedge clk);
    osc_tick = 1'b1;
    if (counting) idx++;
    #1;
    chk(update_stb == (counting && (idx % p == 0)), req, update_stb, counting && (idx % p == 0));
    @(posedge clk);
    #1;
    osc_tick = 1'b0;
    flag_clr = 1'b0;
    chk(upd_busy == busy_exp(p, idx), "R6", upd_busy, busy_exp(p, idx));
  endtask

  task automatic restart(input logic [2:0] m);
    @(negedge clk);
    chain_mode = 3'b110;
    @(negedge clk);
    @(negedge clk);
    chain_mode = m;
    idx = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(update_stb == 0 && upd_busy == 0 && per_flag == 0 && irq == 0, "R1",
        {update_stb, upd_busy, per_flag, irq}, 0);

    // R4: reset code holds, no strobe, busy low
    chain_mode = 3'b111;
    for (int k = 0; k < 40; k++) tick(32768, 1'b0, "R4");

    // R2 + R6: full chain
    restart(3'b010);
    for (int k = 0; k < 32800; k++) tick(32768, 1'b1, "R2");

    // R3: shortened chains
    restart(3'b011);
    for (int k = 0; k < 2100; k++) tick(1024, 1'b1, "R3");
    restart(3'b100);
    for (int k = 0; k < 100; k++) tick(32, 1'b1, "R3");
    restart(3'b101);
    for (int k = 0; k < 40; k++) tick(1, 1'b1, "R3");

    // R5: freeze in the middle of a 32-tick period, then resume
    restart(3'b100);
    for (int k = 0; k < 20; k++) tick(32, 1'b1, "R5");
    @(negedge clk); chain_mode = 3'b001;
    for (int k = 0; k < 30; k++) tick(32, 1'b0, "R5");
    @(negedge clk); chain_mode = 3'b000;
    for (int k = 0; k < 10; k++) tick(32, 1'b0, "R5");
    @(negedge clk); chain_mode = 3'b100;
    for (int k = 0; k < 50; k++) tick(32, 1'b1, "R5");

    // R7, R8, R9: rate sweep
    for (int c = 0; c < 16; c++) begin
      int q;
      restart(3'b010);
      rate_sel = 4'(c);
      clear_flag();
      if (c == 0) begin
        for (int k = 0; k < 600; k++) tick(32768, 1'b1, "R9");
        chk(per_flag == 0, "R9", per_flag, 0);
      end else begin
        q = 1 << (((c == 1) ? 8 : (c == 2) ? 9 : c) - 1);
        for (int k = 0; k < q - 1; k++) tick(32768, 1'b1, (c < 3) ? "R8" : "R7");
        chk(per_flag == 0, (c < 3) ? "R8" : "R7", per_flag, 0);
        tick(32768, 1'b1, (c < 3) ? "R8" : "R7");
        chk(per_flag == 1, (c < 3) ? "R8" : "R7", per_flag, 1);
      end
    end

    // R10, R11: sticky flag, clear, set-over-clear, interrupt gating
    restart(3'b010);
    rate_sel = 4'd3;
    clear_flag();
    for (int k = 0; k < 4; k++) tick(32768, 1'b1, "R10");
    for (int k = 0; k < 3; k++) tick(32768, 1'b1, "R10");
    chk(per_flag == 1, "R10", per_flag, 1);
    per_ie = 1'b0;
    #1;
    chk(irq == 0, "R11", irq, 0);
    per_ie = 1'b1;
    #1;
    chk(irq == 1, "R11", irq, 1);
    clear_flag();
    #1;
    chk(per_flag == 0 && irq == 0, "R10", {per_flag, irq}, 0);
    flag_clr = 1'b1;
    tick(32768, 1'b1, "R10");
    chk(per_flag == 1, "R10", per_flag, 1);
    chk(irq == 1, "R11", irq, 1);
    clear_flag();
    #1;
    chk(irq == 0, "R11", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule